// File: doc/BRIEF.md
# Threaded Bytecode Dispatch Sequencer

This block is the next-PC logic of a small Harvard-architecture core whose firmware runs as an interpreter for a byte-coded virtual machine. It keeps the native program counter and a dedicated virtual program counter (vPC). The vPC is a register of its own, so the general registers stay free for handler code. Each handler ends with one native dispatch instruction. That instruction reads the next bytecode from data RAM at vPC and steps vPC forward. It then jumps straight into a 16-word handler slot in ROM, so control passes from handler to handler with no central loop.

The slot address combines the upper nibble of the page register with the fetched byte. One page value therefore selects a 4K-word block of 256 slots. Moving the page, for example to a block of system functions, changes the whole handler set. When the event input is high at the start of a dispatch, the same instruction breaks out of the thread instead. It jumps to a fixed vector and leaves vPC untouched, so interrupt code can save vPC, run, restore it and dispatch again.

A dispatch takes two cycles, controlled by a two-state machine. In state `ST_RUN` (the state after reset) each ordinary instruction advances the PC. The `DISPATCH_START` transition (`ST_RUN` to `ST_FETCH`) happens when `is_dispatch` is high. It captures the event and page inputs and issues the RAM read. The `DISPATCH_JUMP` transition (`ST_FETCH` to `ST_RUN`) always follows one cycle later. It loads the PC with either the slot address or the vector. While the machine is in `ST_RUN` with `is_dispatch` low, it takes the `STEP` self-transition.

Top module: `bytecode_dispatch`

## Requirements
- R1: Synchronous reset clears `pc` and `vpc_q` to 0x0000, puts the machine in `ST_RUN`, and holds `busy` low.
- R2: In `ST_RUN` with `is_dispatch` low, `pc` increases by one on each clock edge.
- R3: A dispatch with the event low sets `pc` to {page[7:4] in bits 15:12, fetched byte in bits 11:4, 0000 in bits 3:0} on the second edge after `is_dispatch` is seen.
- R4: A dispatch with the event low leaves `vpc_q` one higher than the read address, and 0xFFFF wraps to 0x0000.
- R5: A dispatch with the event high sets `pc` to the parameter VECTOR and leaves `vpc_q` unchanged.
- R6: The event and page are sampled in the first dispatch cycle only. Changes to them in the `ST_FETCH` cycle do not alter the resulting `pc` or `vpc_q`.
- R7: `ram_re` is high only in the `ST_RUN` cycle that has `is_dispatch` high and the event low. In that cycle `ram_addr` equals `vpc_ld_val` when `vpc_ld` is high and `vpc_q` otherwise.
- R8: With `vpc_ld` high, `vpc_q` takes `vpc_ld_val` at the next edge. A load overrides the dispatch increment in the same cycle.
- R9: `busy` is high for exactly the `ST_FETCH` cycle. The `pc` holds in the first dispatch cycle, and `is_dispatch` is ignored while `busy` is high.
- R10: `pc` wraps from 0xFFFF to 0x0000 when it advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| is_dispatch | input | 1 | Current native instruction is the dispatch instruction |
| evt_in | input | 1 | External event request |
| y_page | input | 8 | Page register; the top nibble selects the handler block |
| ram_addr | output | 16 | Data RAM read address |
| ram_re | output | 1 | Data RAM read enable; data is returned one cycle later |
| ram_rdata | input | 8 | Data RAM read data |
| vpc_ld | input | 1 | Load vPC from `vpc_ld_val` |
| vpc_ld_val | input | 16 | Value to load into vPC |
| vpc_q | output | 16 | Current vPC, for save code |
| pc | output | 16 | Native program counter |
| busy | output | 1 | Second cycle of a dispatch in progress |

## Verification
Two functions can fall in the same cycle. A software load of vPC can land on a dispatch: in its start cycle, where the loaded value must also become the read address, or in its jump cycle, where the load must override the increment. The bench sweeps all 256 bytecode values with varied pages and alternates between a separate load cycle and a load merged with the dispatch start. It also places loads in the jump cycle. In every `ST_FETCH` cycle it flips the event and page inputs and raises `is_dispatch` again, then judges `pc` and `vpc_q` against values computed from the address arithmetic alone.

// File: rtl/bdisp_pkg.sv
package bdisp_pkg;
    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_FETCH = 1'b1
    } bd_state_e;
endpackage

// File: rtl/bdisp_ctrl.sv
module bdisp_ctrl
    import bdisp_pkg::*;
#(
    parameter int Y_W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           is_dispatch,
    input  logic           evt_in,
    input  logic [Y_W-1:0] y_in,
    output bd_state_e      state,
    output logic           evt_q,
    output logic [Y_W-1:0] y_q,
    output logic           fetch_go,
    output logic           ram_re,
    output logic           take_jump,
    output logic           take_slot,
    output logic           pc_adv
);
    bd_state_e state_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= state_nxt;
    end

    // transitions: STEP, DISPATCH_START, DISPATCH_JUMP
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN:   if (is_dispatch) state_nxt = ST_FETCH;
            ST_FETCH: state_nxt = ST_RUN;
            default:  state_nxt = ST_RUN;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        fetch_go  = 1'b0;
        ram_re    = 1'b0;
        take_jump = 1'b0;
        take_slot = 1'b0;
        pc_adv    = 1'b0;
        unique case (state)
            ST_RUN: begin
                fetch_go = is_dispatch;
                ram_re   = is_dispatch & ~evt_in;
                pc_adv   = ~is_dispatch;
            end
            ST_FETCH: begin
                take_jump = 1'b1;
                take_slot = ~evt_q;
            end
            default: ;
        endcase
    end

    // event and page captured once, at the start of the dispatch
    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= 1'b0;
            y_q   <= '0;
        end else if (fetch_go) begin
            evt_q <= evt_in;
            y_q   <= y_in;
        end
    end

    p_fetch_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |=> (state == ST_RUN));
    p_sample_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |=> ($stable(evt_q) && $stable(y_q)));
endmodule

// File: rtl/bdisp_vpc.sv
module bdisp_vpc #(
    parameter int VPC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [VPC_W-1:0] ld_val,
    input  logic             inc,
    output logic [VPC_W-1:0] q
);
    localparam logic [VPC_W-1:0] VPC_ONE = {{(VPC_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (ld)  q <= ld_val;
        else if (inc) q <= q + VPC_ONE;
    end

    p_vpc_load_r8: assert property (@(posedge clk) disable iff (rst)
        ld |=> (q == $past(ld_val)));
    p_vpc_inc_r4: assert property (@(posedge clk) disable iff (rst)
        (inc && !ld) |=> (q == $past(q) + VPC_ONE));
    p_vpc_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!inc && !ld) |=> $stable(q));
endmodule

// File: rtl/bdisp_target.sv
module bdisp_target #(
    parameter int             PC_W   = 16,
    parameter int             OP_W   = 8,
    parameter int             SLOT_W = 4,
    parameter int             Y_W    = 8,
    parameter logic [PC_W-1:0] VECTOR = '0
) (
    input  logic [Y_W-1:0]  y_q,
    input  logic [OP_W-1:0] opcode,
    input  logic            evt_q,
    output logic [PC_W-1:0] jump_pc
);
    localparam int PAGE_BITS = PC_W - OP_W - SLOT_W;

    logic [PC_W-1:0] slot_pc;

    generate
        if (PAGE_BITS > 0) begin : g_paged
            assign slot_pc = {y_q[Y_W-1 -: PAGE_BITS], opcode, {SLOT_W{1'b0}}};
        end else begin : g_flat
            assign slot_pc = {opcode, {SLOT_W{1'b0}}};
        end
    endgenerate

    assign jump_pc = evt_q ? VECTOR : slot_pc;
endmodule

// File: rtl/bytecode_dispatch.sv
module bytecode_dispatch
    import bdisp_pkg::*;
#(
    parameter int              PC_W   = 16,
    parameter int              VPC_W  = 16,
    parameter int              OP_W   = 8,
    parameter int              SLOT_W = 4,
    parameter int              Y_W    = 8,
    parameter logic [PC_W-1:0] VECTOR = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             is_dispatch,
    input  logic             evt_in,
    input  logic [Y_W-1:0]   y_page,
    output logic [VPC_W-1:0] ram_addr,
    output logic             ram_re,
    input  logic [OP_W-1:0]  ram_rdata,
    input  logic             vpc_ld,
    input  logic [VPC_W-1:0] vpc_ld_val,
    output logic [VPC_W-1:0] vpc_q,
    output logic [PC_W-1:0]  pc,
    output logic             busy
);
    localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};

    bd_state_e       state;
    logic            evt_q, fetch_go, take_jump, take_slot, pc_adv;
    logic [Y_W-1:0]  y_q;
    logic [PC_W-1:0] jump_pc, pc_q, pc_nxt;

    bdisp_ctrl #(.Y_W(Y_W)) u_ctrl (
        .clk(clk), .rst(rst), .is_dispatch(is_dispatch), .evt_in(evt_in),
        .y_in(y_page), .state(state), .evt_q(evt_q), .y_q(y_q),
        .fetch_go(fetch_go), .ram_re(ram_re), .take_jump(take_jump),
        .take_slot(take_slot), .pc_adv(pc_adv)
    );

    bdisp_vpc #(.VPC_W(VPC_W)) u_vpc (
        .clk(clk), .rst(rst), .ld(vpc_ld), .ld_val(vpc_ld_val),
        .inc(take_slot), .q(vpc_q)
    );

    bdisp_target #(
        .PC_W(PC_W), .OP_W(OP_W), .SLOT_W(SLOT_W), .Y_W(Y_W), .VECTOR(VECTOR)
    ) u_target (
        .y_q(y_q), .opcode(ram_rdata), .evt_q(evt_q), .jump_pc(jump_pc)
    );

    // a load in the start cycle is also the read address
    assign ram_addr = vpc_ld ? vpc_ld_val : vpc_q;

    always_comb begin
        pc_nxt = pc_q;
        if (take_jump)   pc_nxt = jump_pc;
        else if (pc_adv) pc_nxt = pc_q + PC_ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_nxt;
    end

    assign pc   = pc_q;
    assign busy = (state == ST_FETCH);

    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_RUN) && !is_dispatch) |=> (pc == $past(pc) + PC_ONE));
    p_pc_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_RUN) && is_dispatch) |=> $stable(pc));
    p_slot_align_r3: assert property (@(posedge clk) disable iff (rst)
        take_slot |=> (pc[SLOT_W-1:0] == '0));
    p_vector_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && evt_q) |=> (pc == VECTOR));
    p_read_place_r7: assert property (@(posedge clk) disable iff (rst)
        ram_re |-> (!busy && is_dispatch && !evt_in));
    p_busy_single_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);
endmodule

// File: tb/bytecode_dispatch_bench.sv
module bytecode_dispatch_bench;
    localparam logic [15:0] VEC = 16'h8100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        is_dispatch = 1'b0;
    logic        evt_in = 1'b0;
    logic [7:0]  y_page = 8'h00;
    logic [15:0] ram_addr;
    logic        ram_re;
    logic [7:0]  ram_rdata = 8'h00;
    logic        vpc_ld = 1'b0;
    logic [15:0] vpc_ld_val = 16'h0000;
    logic [15:0] vpc_q;
    logic [15:0] pc;
    logic        busy;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [15:0] exp_pc = 16'h0000;

    always #5 clk = ~clk;

    bytecode_dispatch #(.VECTOR(VEC)) u_bytecode_dispatch (
        .clk(clk), .rst(rst), .is_dispatch(is_dispatch), .evt_in(evt_in),
        .y_page(y_page), .ram_addr(ram_addr), .ram_re(ram_re),
        .ram_rdata(ram_rdata), .vpc_ld(vpc_ld), .vpc_ld_val(vpc_ld_val),
        .vpc_q(vpc_q), .pc(pc), .busy(busy)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    // synchronous RAM model, one cycle read latency
    always @(posedge clk) if (ram_re) ram_rdata <= mem_byte(ram_addr);

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_disp(input logic [15:0] addr, input bit comb_load,
                           input bit evt, input logic [7:0] y,
                           input bit ld_fetch, input logic [15:0] ldv);
        logic [15:0] exp_vpc;
        if (!comb_load) begin
            vpc_ld = 1'b1; vpc_ld_val = addr; is_dispatch = 1'b0;
            tick;
            vpc_ld = 1'b0;
            exp_pc = exp_pc + 16'h1;
            chk(pc == exp_pc, "R2 pc step", pc, exp_pc);
            chk(vpc_q == addr, "R8 vpc load", vpc_q, addr);
        end
        is_dispatch = 1'b1; evt_in = evt; y_page = y;
        if (comb_load) begin vpc_ld = 1'b1; vpc_ld_val = addr; end
        #1;
        chk(ram_re == !evt, "R7 read enable", ram_re, !evt);
        if (!evt) chk(ram_addr == addr, "R7 read address", ram_addr, addr);
        tick;
        vpc_ld = 1'b0;
        chk(busy == 1'b1, "R9 busy", busy, 1);
        chk(pc == exp_pc, "R9 pc held", pc, exp_pc);
        // disturb every input during the fetch cycle
        is_dispatch = 1'b1; evt_in = ~evt; y_page = ~y;
        if (ld_fetch) begin vpc_ld = 1'b1; vpc_ld_val = ldv; end
        #1;
        chk(ram_re == 1'b0, "R9 no read while busy", ram_re, 0);
        tick;
        is_dispatch = 1'b0; vpc_ld = 1'b0; evt_in = 1'b0;
        exp_pc  = evt ? VEC : {y[7:4], mem_byte(addr), 4'h0};
        exp_vpc = ld_fetch ? ldv : (evt ? addr : addr + 16'h1);
        chk(pc == exp_pc, evt ? "R5 R6 vector" : "R3 R6 slot target", pc, exp_pc);
        chk(vpc_q == exp_vpc, evt ? "R5 vpc kept" : "R4 R8 vpc after", vpc_q, exp_vpc);
        chk(busy == 1'b0, "R9 busy drops", busy, 0);
    endtask

    initial begin
        tick; tick;
        rst = 1'b0;
        // R1 reset state (pc taken before first advancing edge)
        chk(pc == 16'h0, "R1 pc", pc, 0);
        chk(vpc_q == 16'h0, "R1 vpc", vpc_q, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        exp_pc = 16'h0;
        for (int k = 0; k < 5; k++) begin
            tick;
            exp_pc = exp_pc + 16'h1;
            chk(pc == exp_pc, "R2 pc step", pc, exp_pc);
        end
        // R3 R4 R7 sweep over every bytecode value
        for (int i = 0; i < 256; i++) begin
            logic [7:0]  hi;
            logic [15:0] a;
            hi = 8'(i * 3);
            a  = {hi, 8'(i) ^ hi ^ 8'hA5};
            do_disp(a, i[0], 1'b0, 8'(i * 7), 1'b0, 16'h0);
        end
        // R5 event break-out, vpc kept
        do_disp(16'h1234, 1'b0, 1'b1, 8'h3C, 1'b0, 16'h0);
        do_disp(16'hC0DE, 1'b1, 1'b1, 8'hF0, 1'b0, 16'h0);
        // R4 wrap of vpc
        do_disp(16'hFFFF, 1'b0, 1'b0, 8'h90, 1'b0, 16'h0);
        // R8 load beats increment in the fetch cycle
        do_disp(16'h2222, 1'b1, 1'b0, 8'h50, 1'b1, 16'h4000);
        // R8 load in fetch cycle of an event dispatch
        do_disp(16'h0777, 1'b0, 1'b1, 8'h50, 1'b1, 16'hABCD);
        // R10 pc wrap: jump to 0xFFF0 then advance
        do_disp({8'h00, 8'hFF ^ 8'h00 ^ 8'hA5}, 1'b0, 1'b0, 8'hF0, 1'b0, 16'h0);
        chk(pc == 16'hFFF0, "R10 pc start", pc, 16'hFFF0);
        for (int k = 0; k < 16; k++) begin
            tick;
            exp_pc = exp_pc + 16'h1;
        end
        chk(pc == 16'h0000, "R10 pc wrap", pc, 16'h0000);
        chk(exp_pc == 16'h0000, "R10 model", exp_pc, 0);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule